// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a write-through first-level cache and the next memory level. It holds processor stores, each with its address, in a small set of entries, so the processor continues while memory absorbs the writes. Each entry covers one aligned block of `WORDS` words. It keeps one valid bit per word. A store to a block that already sits in a waiting entry is folded into that entry. This turns runs of stores to neighbouring words into single wide memory writes that carry a word mask.

Entries leave for memory oldest first, one entry per memory transaction. The oldest entry is offered on the memory port as soon as it is valid, and from then on it is locked against further folding. A store to that block starts a fresh entry.

Before a read miss goes to memory, the cache presents its address on the read-check port. The buffer compares it against every valid entry in the same cycle and gives one of three answers:
- **clear**: nothing pending for that block, so the read may go ahead of the buffered writes.
- **forward**: the newest pending copy of the word is returned.
- **hold**: the read must retry after the matching entry has drained.

Forwarding can be disabled by a parameter. With forwarding disabled, every block match answers hold.

Top module: `coalescing_write_buffer`

## Requirements
- R1: After a synchronous active-low reset, no entry is valid: `mem_valid` is 0, `wr_ready` is 1, and every read check answers clear.
- R2: An accepted write whose block is held by no valid entry, or only by the entry being offered to memory, takes a new entry. That entry holds the block address, a mask with only bit `i` set, and the data in lane `i`. Here `i = wr_addr[OFFW-1:0]`, and lane `i` is `mem_data[i*DW +: DW]`. Lanes whose mask bit is 0 carry no meaning, and every offered mask is non-zero.
- R3: An accepted write whose block is held by a valid entry that is not being offered to memory sets that entry's mask bit for the word and overwrites the lane. It uses no new entry.
- R4: Whenever the oldest entry is valid, it is offered with `mem_valid` = 1. `mem_addr` is its block address with the low `OFFW` bits zero. `mem_addr`, `mem_data` and `mem_mask` stay stable until `mem_ready` is 1.
- R5: Entries are written to memory in the order they were allocated. Each cycle with `mem_valid` and `mem_ready` both 1 retires exactly one entry.
- R6: `wr_ready` is 0 only when all `DEPTH` entries are valid and the presented write cannot merge. A write presented while `wr_ready` is 0 is ignored.
- R7: A read check whose block matches no valid entry answers `rd_clear` in the same cycle.
- R8: With `FWD_EN`=1, a read check whose word is held by a matching entry answers `rd_fwd`. `rd_data` carries the value from the youngest entry that holds that word.
- R9: A read check whose block matches but whose word cannot be forwarded (always the case with `FWD_EN`=0) answers `rd_hold`.
- R10: A write accepted at a clock edge is not seen by a read check in the cycle it is presented. It is seen from the next cycle on.
- R11: While `rd_valid` is 1, exactly one of `rd_clear`, `rd_fwd`, `rd_hold` is 1. While `rd_valid` is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Processor write present |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Write accepted this cycle if valid |
| rd_valid | input | 1 | Read-miss check present |
| rd_addr | input | AW | Word address of the read miss |
| rd_clear | output | 1 | No pending write for the block |
| rd_fwd | output | 1 | Word forwarded on rd_data |
| rd_hold | output | 1 | Read must wait for the drain |
| rd_data | output | DW | Forwarded word |
| mem_valid | output | 1 | Block write offered to memory |
| mem_addr | output | AW | Block-aligned word address |
| mem_data | output | WORDS*DW | Block data, one lane per word |
| mem_mask | output | WORDS | Per-word write enables |
| mem_ready | input | 1 | Memory takes the offered write |

## Verification
The assertions take two things for granted about the inputs:
- `mem_ready` is a plain accept in the cycle it is high, with no requirement that it stay high.
- Read checks may arrive in any cycle, including the cycle of a write to the same word.

The stability property relies on the memory side never withdrawing a transaction the buffer has not yet seen accepted. The stimulus drives every input only at the falling edge, and it holds `mem_ready` low while entries are built up. This exercises merging, the full-buffer stall, and the locked oldest entry before any draining begins.

// File: rtl/cwb_pkg.sv
// Shared types and helpers for the coalescing write buffer.
// Assumes entry indices fit in 32 bits.
package cwb_pkg;

    // Answer given to a read-miss check.
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_CLEAR = 2'd1,
        RSP_FWD   = 2'd2,
        RSP_HOLD  = 2'd3
    } rd_rsp_e;

    // Index that lies `step` places after `base` in a ring of `depth` slots.
    function automatic int unsigned ring_idx(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned depth);
        return (base + step) % depth;
    endfunction

endpackage

// File: rtl/cwb_entry.sv
// One buffer entry: a valid flag, a block address, per-word valid bits and
// one data lane per word.
// Assumes alloc_i and merge_i are never high together. Assumes release_i
// only targets a valid entry and never coincides with alloc_i.
module cwb_entry #(
    parameter  int AW    = 16,
    parameter  int DW    = 32,
    parameter  int WORDS = 4,
    localparam int OFFW  = $clog2(WORDS),
    localparam int BW    = AW - OFFW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic                  merge_i,
    input  logic                  release_i,
    input  logic [OFFW-1:0]       word_i,
    input  logic [BW-1:0]         blk_i,
    input  logic [DW-1:0]         data_i,
    output logic                  valid_o,
    output logic [BW-1:0]         blk_o,
    output logic [WORDS-1:0]      mask_o,
    output logic [WORDS*DW-1:0]   data_o
);

    // Entry state update: reset, retire, allocate or fold a word in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            blk_o   <= '0;
            mask_o  <= '0;
            data_o  <= '0;
        end else begin
            if (release_i) begin
                valid_o <= 1'b0;
            end
            if (alloc_i) begin
                valid_o <= 1'b1;
                blk_o   <= blk_i;
            end
            for (int w = 0; w < WORDS; w++) begin
                if (alloc_i) begin
                    mask_o[w] <= (w == int'(word_i));
                end else if (merge_i && (w == int'(word_i))) begin
                    mask_o[w] <= 1'b1;
                end
                if ((alloc_i || merge_i) && (w == int'(word_i))) begin
                    data_o[w*DW +: DW] <= data_i;
                end
            end
        end
    end

endmodule

// File: rtl/cwb_order_ctl.sv
// Allocation order of the entries: a ring with a head (oldest) pointer,
// a tail (next free) pointer and an occupancy count.
// Assumes push_i is never high while full_o is high, and pop_i never while
// the ring is empty.
module cwb_order_ctl #(
    parameter  int DEPTH = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [IW-1:0] head_o,
    output logic [IW-1:0] tail_o,
    output logic          full_o
);

    logic [CW-1:0] count_q;

    // Pointer and count update on allocation and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_o  <= '0;
            tail_o  <= '0;
            count_q <= '0;
        end else begin
            if (push_i) begin
                tail_o <= (tail_o == IW'(DEPTH - 1)) ? '0 : tail_o + 1'b1;
            end
            if (pop_i) begin
                head_o <= (head_o == IW'(DEPTH - 1)) ? '0 : head_o + 1'b1;
            end
            case ({push_i, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Full when every entry is allocated.
    always_comb begin
        full_o = (count_q == CW'(DEPTH));
    end

endmodule

// File: rtl/cwb_lookup.sv
// Associative search over all entries.
// For writes it finds an unlocked entry of the same block (the head entry is
// being offered to memory and is excluded). For read checks it classifies the
// answer and picks the youngest holder of the word.
// Assumes at most one unlocked entry per block, which the allocation rule
// guarantees.
module cwb_lookup
    import cwb_pkg::*;
#(
    parameter  int AW     = 16,
    parameter  int DW     = 32,
    parameter  int WORDS  = 4,
    parameter  int DEPTH  = 4,
    parameter  bit FWD_EN = 1'b1,
    localparam int OFFW   = $clog2(WORDS),
    localparam int BW     = AW - OFFW,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]                 ent_valid_i,
    input  logic [DEPTH-1:0][BW-1:0]         ent_blk_i,
    input  logic [DEPTH-1:0][WORDS-1:0]      ent_mask_i,
    input  logic [DEPTH-1:0][WORDS*DW-1:0]   ent_data_i,
    input  logic [IW-1:0]                    head_i,
    input  logic [BW-1:0]                    wr_blk_i,
    input  logic                             rd_valid_i,
    input  logic [BW-1:0]                    rd_blk_i,
    input  logic [OFFW-1:0]                  rd_word_i,
    output logic                             merge_hit_o,
    output logic [IW-1:0]                    merge_idx_o,
    output rd_rsp_e                          rsp_o,
    output logic [DW-1:0]                    fwd_data_o
);

    logic blk_match;
    logic word_hit;
    logic can_fwd;

    // Write side: find an unlocked valid entry of the same block.
    always_comb begin
        merge_hit_o = 1'b0;
        merge_idx_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ent_valid_i[k] && (k != int'(head_i)) && (ent_blk_i[k] == wr_blk_i)) begin
                merge_hit_o = 1'b1;
                merge_idx_o = IW'(k);
            end
        end
    end

    // Read side: walk oldest to youngest, so the last holder seen wins.
    always_comb begin
        int unsigned idx;
        blk_match  = 1'b0;
        word_hit   = 1'b0;
        fwd_data_o = '0;
        for (int a = 0; a < DEPTH; a++) begin
            idx = ring_idx(int'(head_i), a, DEPTH);
            if (ent_valid_i[idx] && (ent_blk_i[idx] == rd_blk_i)) begin
                blk_match = 1'b1;
                if (ent_mask_i[idx][rd_word_i]) begin
                    word_hit   = 1'b1;
                    fwd_data_o = ent_data_i[idx][int'(rd_word_i)*DW +: DW];
                end
            end
        end
    end

    // Variant choice: forward pending words or always hold on a match.
    if (FWD_EN) begin : g_forward
        assign can_fwd = word_hit;
    end else begin : g_hold_only
        assign can_fwd = 1'b0;
    end

    // Classify the read-check answer.
    always_comb begin
        if (!rd_valid_i) begin
            rsp_o = RSP_NONE;
        end else if (!blk_match) begin
            rsp_o = RSP_CLEAR;
        end else if (can_fwd) begin
            rsp_o = RSP_FWD;
        end else begin
            rsp_o = RSP_HOLD;
        end
    end

endmodule

// File: rtl/coalescing_write_buffer.sv
// Coalescing write buffer between a write-through cache and memory.
// Stores are folded per block into DEPTH entries. The entries drain oldest
// first as masked block writes, and read misses are checked against all
// pending entries.
// Assumes WORDS and DEPTH are powers of two no smaller than 2, and that
// AW exceeds log2(WORDS).
module coalescing_write_buffer
    import cwb_pkg::*;
#(
    parameter  int AW     = 16,
    parameter  int DW     = 32,
    parameter  int WORDS  = 4,
    parameter  int DEPTH  = 4,
    parameter  bit FWD_EN = 1'b1,
    localparam int OFFW   = $clog2(WORDS),
    localparam int BW     = AW - OFFW,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic                 wr_ready,
    input  logic                 rd_valid,
    input  logic [AW-1:0]        rd_addr,
    output logic                 rd_clear,
    output logic                 rd_fwd,
    output logic                 rd_hold,
    output logic [DW-1:0]        rd_data,
    output logic                 mem_valid,
    output logic [AW-1:0]        mem_addr,
    output logic [WORDS*DW-1:0]  mem_data,
    output logic [WORDS-1:0]     mem_mask,
    input  logic                 mem_ready
);

    logic [DEPTH-1:0]               ent_valid;
    logic [DEPTH-1:0][BW-1:0]       ent_blk;
    logic [DEPTH-1:0][WORDS-1:0]    ent_mask;
    logic [DEPTH-1:0][WORDS*DW-1:0] ent_data;
    logic [IW-1:0]                  head;
    logic [IW-1:0]                  tail;
    logic                           full;
    logic                           merge_hit;
    logic [IW-1:0]                  merge_idx;
    logic                           do_merge;
    logic                           do_alloc;
    logic                           do_drain;
    logic [DW-1:0]                  fwd_word;
    rd_rsp_e                        rsp;

    cwb_order_ctl #(.DEPTH(DEPTH)) u_order (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (do_alloc),
        .pop_i  (do_drain),
        .head_o (head),
        .tail_o (tail),
        .full_o (full)
    );

    cwb_lookup #(
        .AW(AW), .DW(DW), .WORDS(WORDS), .DEPTH(DEPTH), .FWD_EN(FWD_EN)
    ) u_lookup (
        .ent_valid_i (ent_valid),
        .ent_blk_i   (ent_blk),
        .ent_mask_i  (ent_mask),
        .ent_data_i  (ent_data),
        .head_i      (head),
        .wr_blk_i    (wr_addr[AW-1:OFFW]),
        .rd_valid_i  (rd_valid),
        .rd_blk_i    (rd_addr[AW-1:OFFW]),
        .rd_word_i   (rd_addr[OFFW-1:0]),
        .merge_hit_o (merge_hit),
        .merge_idx_o (merge_idx),
        .rsp_o       (rsp),
        .fwd_data_o  (fwd_word)
    );

    // Write acceptance and the split into merge versus allocate.
    always_comb begin
        wr_ready = !full || merge_hit;
        do_merge = wr_valid && wr_ready && merge_hit;
        do_alloc = wr_valid && wr_ready && !merge_hit;
        do_drain = ent_valid[head] && mem_ready;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        cwb_entry #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (do_alloc && (tail == IW'(g))),
            .merge_i   (do_merge && (merge_idx == IW'(g))),
            .release_i (do_drain && (head == IW'(g))),
            .word_i    (wr_addr[OFFW-1:0]),
            .blk_i     (wr_addr[AW-1:OFFW]),
            .data_i    (wr_data),
            .valid_o   (ent_valid[g]),
            .blk_o     (ent_blk[g]),
            .mask_o    (ent_mask[g]),
            .data_o    (ent_data[g])
        );
    end

    // Memory port: offer the oldest entry as a masked block write.
    always_comb begin
        mem_valid = ent_valid[head];
        mem_addr  = {ent_blk[head], {OFFW{1'b0}}};
        mem_data  = ent_data[head];
        mem_mask  = ent_mask[head];
    end

    // Read-check answer decode.
    always_comb begin
        rd_clear = (rsp == RSP_CLEAR);
        rd_fwd   = (rsp == RSP_FWD);
        rd_hold  = (rsp == RSP_HOLD);
        rd_data  = (rsp == RSP_FWD) ? fwd_word : '0;
    end

endmodule

// File: rtl/cwb_checker.sv
// Port-level properties of the coalescing write buffer, bound to every
// instance of the top module.
// Assumes the memory side treats mem_ready as a plain accept.
module cwb_checker #(
    parameter  int AW    = 16,
    parameter  int DW    = 32,
    parameter  int WORDS = 4,
    localparam int OFFW  = $clog2(WORDS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_ready,
    input logic                 rd_valid,
    input logic                 rd_clear,
    input logic                 rd_fwd,
    input logic                 rd_hold,
    input logic                 mem_valid,
    input logic [AW-1:0]        mem_addr,
    input logic [WORDS*DW-1:0]  mem_data,
    input logic [WORDS-1:0]     mem_mask,
    input logic                 mem_ready
);

    // R1: the first cycle after reset shows an empty buffer.
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!mem_valid && wr_ready));

    // R2: an offered block always carries at least one word.
    p_mask_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_mask != '0));

    // R4: the offered address is block aligned.
    p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFFW-1:0] == '0));

    // R4: a waiting transaction holds still until it is accepted.
    p_offer_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_mask)));

    // R6: a stall means the buffer holds something to drain.
    p_stall_only_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> mem_valid);

    // R11: exactly one answer per read check.
    p_one_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $onehot({rd_clear, rd_fwd, rd_hold}));

    // R11: no answer without a read check.
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !(rd_clear || rd_fwd || rd_hold));

endmodule

bind coalescing_write_buffer cwb_checker #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_cwb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_clear  (rd_clear),
    .rd_fwd    (rd_fwd),
    .rd_hold   (rd_hold),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_mask  (mem_mask),
    .mem_ready (mem_ready)
);

// File: tb/coalescing_write_buffer_test.sv
// Scoreboard bench: the driver queues the expected memory writes, and the
// monitor compares each accepted memory transaction with the queue head.
module coalescing_write_buffer_test;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int WORDS = 4;
    localparam int DEPTH = 4;

    typedef struct packed {
        logic [AW-1:0]       a;
        logic [WORDS-1:0]    m;
        logic [WORDS*DW-1:0] d;
    } txn_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_ready;
    logic rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic rd_clear, rd_fwd, rd_hold;
    logic [DW-1:0] rd_data;
    logic mem_valid;
    logic [AW-1:0] mem_addr;
    logic [WORDS*DW-1:0] mem_data;
    logic [WORDS-1:0] mem_mask;
    logic mem_ready = 1'b0;

    logic nf_wr_ready, nf_clear, nf_fwd, nf_hold, nf_mem_valid;
    logic [DW-1:0] nf_rd_data;
    logic [AW-1:0] nf_mem_addr;
    logic [WORDS*DW-1:0] nf_mem_data;
    logic [WORDS-1:0] nf_mem_mask;

    int n_checks = 0;
    int n_fail = 0;
    txn_t exp_q[$];

    always #5 clk = ~clk;

    coalescing_write_buffer #(.AW(AW), .DW(DW), .WORDS(WORDS), .DEPTH(DEPTH), .FWD_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_clear(rd_clear),
        .rd_fwd(rd_fwd), .rd_hold(rd_hold), .rd_data(rd_data), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask), .mem_ready(mem_ready));

    coalescing_write_buffer #(.AW(AW), .DW(DW), .WORDS(WORDS), .DEPTH(DEPTH), .FWD_EN(1'b0)) uut_nf (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(nf_wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_clear(nf_clear),
        .rd_fwd(nf_fwd), .rd_hold(nf_hold), .rd_data(nf_rd_data), .mem_valid(nf_mem_valid),
        .mem_addr(nf_mem_addr), .mem_data(nf_mem_data), .mem_mask(nf_mem_mask), .mem_ready(mem_ready));

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic txn_t mk(input logic [AW-1:0] a, input logic [WORDS-1:0] m,
                                input logic [DW-1:0] l0, input logic [DW-1:0] l1,
                                input logic [DW-1:0] l2, input logic [DW-1:0] l3);
        txn_t t;
        t.a = a;
        t.m = m;
        t.d = {l3, l2, l1, l0};
        return t;
    endfunction

    // Driver: present one write for one clock edge.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Read check on both instances; expected answers coded {clear,fwd,hold}.
    task automatic read_chk(input logic [AW-1:0] a, input logic [2:0] exp_rsp,
                            input logic [DW-1:0] exp_d, input logic [2:0] exp_nf,
                            input string req);
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr = a;
        #1;
        check({rd_clear, rd_fwd, rd_hold} == exp_rsp,
              $sformatf("%s read %h answer actual %b expected %b", req, a,
                        {rd_clear, rd_fwd, rd_hold}, exp_rsp));
        if (exp_rsp == 3'b010)
            check(rd_data == exp_d, $sformatf("%s read %h data actual %h expected %h",
                                              req, a, rd_data, exp_d));
        check({nf_clear, nf_fwd, nf_hold} == exp_nf,
              $sformatf("R9 no-forward read %h answer actual %b expected %b", a,
                        {nf_clear, nf_fwd, nf_hold}, exp_nf));
        rd_valid = 1'b0;
    endtask

    // Monitor: compare every accepted memory write with the queue head (R4, R5).
    always begin
        @(negedge clk);
        #2;
        if (rst_n && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, $sformatf("R5 unexpected write actual %h expected none", mem_addr));
            end else begin
                txn_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.a, $sformatf("R4 address actual %h expected %h", mem_addr, e.a));
                check(mem_mask == e.m, $sformatf("R5 mask actual %b expected %b", mem_mask, e.m));
                for (int w = 0; w < WORDS; w++) begin
                    if (e.m[w])
                        check(mem_data[w*DW +: DW] == e.d[w*DW +: DW],
                              $sformatf("R2 lane %0d actual %h expected %h", w,
                                        mem_data[w*DW +: DW], e.d[w*DW +: DW]));
                end
            end
        end
    end

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty state after reset.
        check(mem_valid == 1'b0, $sformatf("R1 mem_valid actual %b expected 0", mem_valid));
        check(wr_ready == 1'b1, $sformatf("R1 wr_ready actual %b expected 1", wr_ready));
        read_chk(16'h0100, 3'b100, '0, 3'b100, "R1");
        #1;
        check({rd_clear, rd_fwd, rd_hold} == 3'b000,
              $sformatf("R11 idle answer actual %b expected 000", {rd_clear, rd_fwd, rd_hold}));

        // Build entries with memory stalled.
        do_write(16'h0100, 32'hA000_0000);   // new entry, head (R2)
        do_write(16'h0101, 32'hB100_0001);   // head locked: new entry (R2)
        do_write(16'h0102, 32'hB200_0002);   // merge (R3)
        do_write(16'h0101, 32'hB1EE_0011);   // merge overwrite (R3)
        do_write(16'h0200, 32'hC000_0000);
        do_write(16'h0300, 32'hE000_0000);
        #1;
        check(mem_valid && mem_addr == 16'h0100 && mem_mask == 4'b0001,
              $sformatf("R4 offer actual %b %h %b expected 1 0100 0001", mem_valid, mem_addr, mem_mask));
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr = 16'h0400;
        wr_data = 32'hDEAD_0400;
        #1;
        check(wr_ready == 1'b0, $sformatf("R6 full stall actual %b expected 0", wr_ready));
        wr_addr = 16'h0203;
        wr_data = 32'hD300_0003;
        #1;
        check(wr_ready == 1'b1, $sformatf("R6 merge while full actual %b expected 1", wr_ready));
        @(negedge clk);
        wr_valid = 1'b0;

        read_chk(16'h0101, 3'b010, 32'hB1EE_0011, 3'b001, "R8 newest");
        read_chk(16'h0100, 3'b010, 32'hA000_0000, 3'b001, "R8 older holder");
        read_chk(16'h0203, 3'b010, 32'hD300_0003, 3'b001, "R3 merged when full");
        read_chk(16'h0103, 3'b001, '0, 3'b001, "R9 word absent");
        read_chk(16'h0500, 3'b100, '0, 3'b100, "R7 no match");
        read_chk(16'h0400, 3'b100, '0, 3'b100, "R6 ignored write");

        exp_q.push_back(mk(16'h0100, 4'b0001, 32'hA000_0000, '0, '0, '0));
        exp_q.push_back(mk(16'h0100, 4'b0110, '0, 32'hB1EE_0011, 32'hB200_0002, '0));
        exp_q.push_back(mk(16'h0200, 4'b1001, 32'hC000_0000, '0, '0, 32'hD300_0003));
        exp_q.push_back(mk(16'h0300, 4'b0001, 32'hE000_0000, '0, '0, '0));
        @(negedge clk);
        mem_ready = 1'b1;
        repeat (6) @(negedge clk);
        mem_ready = 1'b0;
        #3;
        check(exp_q.size() == 0, $sformatf("R5 pending writes actual %0d expected 0", exp_q.size()));
        check(mem_valid == 1'b0 && wr_ready == 1'b1,
              $sformatf("R5 drained actual %b %b expected 0 1", mem_valid, wr_ready));

        // R10: a write is invisible to a read check in its own cycle.
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr = 16'h0700;
        wr_data = 32'hF000_0700;
        rd_valid = 1'b1;
        rd_addr = 16'h0700;
        #1;
        check(rd_clear == 1'b1, $sformatf("R10 same cycle clear actual %b expected 1", rd_clear));
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        check(rd_fwd == 1'b1 && rd_data == 32'hF000_0700,
              $sformatf("R10 next cycle actual %b %h expected 1 f0000700", rd_fwd, rd_data));
        rd_valid = 1'b0;
        do_write(16'h0702, 32'h6000_0702);   // head holds block: new entry (R2)
        read_chk(16'h0702, 3'b010, 32'h6000_0702, 3'b001, "R8 second entry");
        read_chk(16'h0701, 3'b001, '0, 3'b001, "R9 hold");
        exp_q.push_back(mk(16'h0700, 4'b0001, 32'hF000_0700, '0, '0, '0));
        exp_q.push_back(mk(16'h0700, 4'b0100, '0, '0, 32'h6000_0702, '0));
        @(negedge clk);
        mem_ready = 1'b1;
        repeat (4) @(negedge clk);
        #3;
        check(exp_q.size() == 0, $sformatf("R5 second drain actual %0d expected 0", exp_q.size()));
        read_chk(16'h0700, 3'b100, '0, 3'b100, "R7 after drain");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual running expected finished");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule